// File: doc/BRIEF.md
# Watchdog Timer with Frequency-Select Recovery

This block protects a system while software changes the clock frequency. Software arms a countdown with a 5-bit value and chooses one of two tick periods: a short one or a long one. While the watchdog is enabled and armed, the countdown moves once per tick. If software does not reload the count before the countdown runs out, the block does three things. It raises a status flag that stays set until software clears it. It drives a system reset pulse of a fixed length. It replaces the active frequency-select code with a fixed recovery code.

The block also chooses the frequency-select code in normal operation. The code is either the strap value captured during reset or a code that software writes, and an override bit picks between the two. The register interface is reduced to write strobes with data. The current count is brought out so that software can read it. The tick periods are set by clock-count parameters, so a simulation can use short ticks.

Top module: `wdg_freq_guard`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `timeout_status` and `sys_reset` are 0, the control and select registers are 0, the timer is disarmed, and `fs_out` equals the strap value that was present during reset.
- R2: `strap_fs` is sampled only while `rst` is high. A change on `strap_fs` after reset has no effect on `fs_out`.
- R3: When `timeout_status` is 0, `fs_out` shows the captured strap code if the override bit is 0, and the software select code if the override bit is 1.
- R4: The tick period is FAST_CLKS clocks when the timebase bit is 0 and SLOW_CLKS clocks when it is 1. Writing count N (0 to 31) while the timer is enabled sets `timeout_status` on exactly the clock edge (N+1)×period after the edge that takes the write.
- R5: Writing the count while the countdown is running restarts both the count and the tick phase from the edge of that write. On the next cycle the count reads back as the value written.
- R6: While the enable bit is 0, the tick phase is held at zero, `count_now` keeps its value and no time-out occurs.
- R7: `timeout_status` stays set until `status_clr` is high at a clock edge. When a time-out and a clear fall on the same edge, the status ends set.
- R8: `sys_reset` rises on the same edge as `timeout_status` and stays high for exactly RST_CYCLES clocks.
- R9: While `timeout_status` is 1, `fs_out` equals RECOVERY_FS whatever the override bit is. After the clear, `fs_out` returns to the selected code.
- R10: A time-out disarms the timer. After the status is cleared, no new time-out occurs until software writes the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the strap code is captured while it is high |
| strap_fs | input | 5 | Strap frequency code |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_enable | input | 1 | Control data: enables the watchdog |
| ctrl_slow | input | 1 | Control data: timebase, 0 for the short tick and 1 for the long tick |
| ctrl_override | input | 1 | Control data: 1 selects the software code instead of the strap code |
| sel_we | input | 1 | Write strobe for the software select code |
| sel_code | input | 5 | Software frequency code |
| count_we | input | 1 | Count write; arms the timer and restarts the countdown |
| count_val | input | 5 | Count value N; time-out after N+1 ticks |
| status_clr | input | 1 | Write-one-to-clear for the time-out status |
| timeout_status | output | 1 | Sticky time-out flag |
| sys_reset | output | 1 | System reset pulse |
| fs_out | output | 5 | Active frequency-select code |
| count_now | output | 5 | Current countdown value |

## Verification
The bench sweeps every count value under both timebases and samples the status one cycle before and exactly at the expected expiry edge. A design with an off-by-one error in the count or in the tick phase would fail this check by one tick or one clock. It also checks the reset pulse length and the recovery code, so a pulse that is too short or too long, or a recovery code that depends on the override bit, is caught.

The bench reloads the count in the middle of a countdown and checks that expiry is timed from the reload edge. A design that kept the old tick phase would expire early. It disables the timer and checks that the count freezes with no time-out.

It clears the status and checks that the timer stays disarmed, so a design that fires again after the clear is caught. It also drives a clear on the same edge as a time-out, which shows whether the clear wrongly takes priority over the new time-out.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int CNT_W = 5;
    localparam int FS_W  = 5;

    typedef logic [FS_W-1:0]  fs_code_t;
    typedef logic [CNT_W-1:0] wd_count_t;

    typedef enum logic {
        TB_FAST = 1'b0,
        TB_SLOW = 1'b1
    } timebase_e;

    typedef struct packed {
        logic      enable;
        timebase_e timebase;
        logic      override;
    } wd_ctrl_t;

    function automatic int width_for(int unsigned v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

    function automatic fs_code_t choose_fs(logic recover, logic override,
                                           fs_code_t rec_code, fs_code_t sw_code,
                                           fs_code_t strap_code);
        if (recover)       return rec_code;
        else if (override) return sw_code;
        else               return strap_code;
    endfunction

endpackage

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen
    import wdg_pkg::*;
#(
    parameter int FAST_CLKS = 4,
    parameter int SLOW_CLKS = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      restart,
    input  timebase_e timebase,
    output logic      tick
);
    localparam int MAXC = (FAST_CLKS > SLOW_CLKS) ? FAST_CLKS : SLOW_CLKS;
    localparam int PW   = width_for(MAXC);

    logic [PW-1:0] phase;
    logic [PW-1:0] last;
    logic          at_end;

    always_comb begin
        if (timebase == TB_SLOW) last = PW'(SLOW_CLKS - 1);
        else                     last = PW'(FAST_CLKS - 1);
    end

    assign at_end = (phase >= last);
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || restart) phase <= '0;
        else if (at_end)            phase <= '0;
        else                        phase <= phase + 1'b1;
    end

    AST_PHASE_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !run |=> phase == '0);  // R6

endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown
    import wdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      load,
    input  wd_count_t load_val,
    input  logic      clr,
    output wd_count_t count,
    output logic      armed,
    output logic      status,
    output logic      expire
);
    assign expire = tick && armed && (count == '0) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            armed  <= 1'b0;
            status <= 1'b0;
        end else begin
            if (load)
                count <= load_val;
            else if (tick && armed && count != '0)
                count <= count - 1'b1;

            if (load)        armed <= 1'b1;
            else if (expire) armed <= 1'b0;

            if (expire)   status <= 1'b1;
            else if (clr) status <= 1'b0;
        end
    end

    AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val));  // R5

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        status && !clr |=> status);  // R7

    AST_DISARM_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> !armed);  // R10

endmodule

// File: rtl/wdg_pulse_gen.sv
module wdg_pulse_gen #(
    parameter int RST_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic pulse
);
    localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)               remain <= '0;
        else if (fire)         remain <= CW'(RST_CYCLES);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign pulse = (remain != '0);

endmodule

// File: rtl/wdg_fs_select.sv
module wdg_fs_select
    import wdg_pkg::*;
#(
    parameter fs_code_t RECOVERY_FS = 5'h0B
) (
    input  logic     clk,
    input  logic     rst,
    input  fs_code_t strap_fs,
    input  fs_code_t sw_code,
    input  logic     override,
    input  logic     recover,
    output fs_code_t fs_out
);
    fs_code_t strap_q;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_fs;
    end

    assign fs_out = choose_fs(recover, override, RECOVERY_FS, sw_code, strap_q);

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $stable(strap_q));  // R2

endmodule

// File: rtl/wdg_freq_guard.sv
module wdg_freq_guard
    import wdg_pkg::*;
#(
    parameter int       FAST_CLKS   = 4,
    parameter int       SLOW_CLKS   = 7,
    parameter int       RST_CYCLES  = 3,
    parameter fs_code_t RECOVERY_FS = 5'h0B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [4:0] strap_fs,
    input  logic       ctrl_we,
    input  logic       ctrl_enable,
    input  logic       ctrl_slow,
    input  logic       ctrl_override,
    input  logic       sel_we,
    input  logic [4:0] sel_code,
    input  logic       count_we,
    input  logic [4:0] count_val,
    input  logic       status_clr,
    output logic       timeout_status,
    output logic       sys_reset,
    output logic [4:0] fs_out,
    output logic [4:0] count_now
);
    localparam int HW = (RST_CYCLES < 2) ? 2 : $clog2(RST_CYCLES + 2);

    wd_ctrl_t  ctrl_q;
    fs_code_t  sel_q;
    logic      tick;
    logic      armed;
    logic      expire;
    wd_count_t count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            if (ctrl_we) begin
                ctrl_q.enable   <= ctrl_enable;
                ctrl_q.timebase <= timebase_e'(ctrl_slow);
                ctrl_q.override <= ctrl_override;
            end
            if (sel_we) sel_q <= sel_code;
        end
    end

    wdg_tick_gen #(
        .FAST_CLKS (FAST_CLKS),
        .SLOW_CLKS (SLOW_CLKS)
    ) u_tick (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.enable && armed),
        .restart  (count_we),
        .timebase (ctrl_q.timebase),
        .tick     (tick)
    );

    wdg_countdown u_count (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (count_we),
        .load_val (count_val),
        .clr      (status_clr),
        .count    (count_q),
        .armed    (armed),
        .status   (timeout_status),
        .expire   (expire)
    );

    wdg_pulse_gen #(
        .RST_CYCLES (RST_CYCLES)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (expire),
        .pulse (sys_reset)
    );

    wdg_fs_select #(
        .RECOVERY_FS (RECOVERY_FS)
    ) u_fs (
        .clk      (clk),
        .rst      (rst),
        .strap_fs (strap_fs),
        .sw_code  (sel_q),
        .override (ctrl_q.override),
        .recover  (timeout_status),
        .fs_out   (fs_out)
    );

    assign count_now = count_q;

    // Length of the current reset pulse, for checking only
    logic [HW-1:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst)            hi_len <= '0;
        else if (!sys_reset) hi_len <= '0;
        else if (hi_len != '1) hi_len <= hi_len + 1'b1;
    end

    AST_PULSE_AT_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_status) |-> sys_reset);  // R8

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        hi_len <= HW'(RST_CYCLES));  // R8

    AST_RECOVERY_HELD: assert property (@(posedge clk) disable iff (rst)
        timeout_status |-> fs_out == RECOVERY_FS);  // R9

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.enable && !count_we |=> $stable(count_now) && !$rose(timeout_status));  // R6

endmodule

// File: tb/wdg_freq_guard_test.sv
`timescale 1ns/1ps
module wdg_freq_guard_test;

    localparam int FAST = 4;
    localparam int SLOW = 7;
    localparam int RSTC = 3;
    localparam logic [4:0] REC = 5'h0B;
    localparam logic [4:0] STRAP = 5'h12;

    logic clk = 0;
    logic rst = 1;
    logic [4:0] strap_fs = STRAP;
    logic ctrl_we = 0, ctrl_enable = 0, ctrl_slow = 0, ctrl_override = 0;
    logic sel_we = 0;
    logic [4:0] sel_code = 0;
    logic count_we = 0;
    logic [4:0] count_val = 0;
    logic status_clr = 0;
    logic timeout_status, sys_reset;
    logic [4:0] fs_out, count_now;

    int total = 0;
    int failed = 0;

    always #4 clk = ~clk;

    wdg_freq_guard #(
        .FAST_CLKS   (FAST),
        .SLOW_CLKS   (SLOW),
        .RST_CYCLES  (RSTC),
        .RECOVERY_FS (REC)
    ) uut (
        .clk            (clk),
        .rst            (rst),
        .strap_fs       (strap_fs),
        .ctrl_we        (ctrl_we),
        .ctrl_enable    (ctrl_enable),
        .ctrl_slow      (ctrl_slow),
        .ctrl_override  (ctrl_override),
        .sel_we         (sel_we),
        .sel_code       (sel_code),
        .count_we       (count_we),
        .count_val      (count_val),
        .status_clr     (status_clr),
        .timeout_status (timeout_status),
        .sys_reset      (sys_reset),
        .fs_out         (fs_out),
        .count_now      (count_now)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic en, input logic slow, input logic ov);
        @(negedge clk);
        ctrl_we = 1; ctrl_enable = en; ctrl_slow = slow; ctrl_override = ov;
        @(negedge clk);
        ctrl_we = 0;
    endtask

    // Leaves the bench half a cycle after the load edge
    task automatic load_count(input logic [4:0] n);
        @(negedge clk);
        count_we = 1; count_val = n;
        @(negedge clk);
        count_we = 0;
    endtask

    task automatic clear_status;
        @(negedge clk);
        status_clr = 1;
        @(negedge clk);
        status_clr = 0;
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        failed++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        finish_run();
    end

    initial begin
        wait_cycles(3);
        // R1: state during reset
        check("R1 status in reset", timeout_status, 0);
        check("R1 sys_reset in reset", sys_reset, 0);
        rst = 0;
        @(negedge clk);
        check("R1 status after reset", timeout_status, 0);
        check("R1 fs after reset", fs_out, STRAP);
        check("R1 count after reset", count_now, 0);

        // R2: strap change after reset is ignored
        strap_fs = 5'h03;
        wait_cycles(4);
        check("R2 strap frozen", fs_out, STRAP);

        // R3: override selects the software code
        @(negedge clk); sel_we = 1; sel_code = 5'h15;
        @(negedge clk); sel_we = 0;
        check("R3 strap still selected", fs_out, STRAP);
        write_ctrl(0, 0, 1);
        check("R3 sw code selected", fs_out, 5'h15);
        write_ctrl(0, 0, 0);
        check("R3 back to strap", fs_out, STRAP);

        // R6: disabled timer does not count
        load_count(5'd9);
        wait_cycles(100);
        check("R6 no expiry when disabled", timeout_status, 0);
        check("R6 count held", count_now, 9);

        // R4 / R8 / R9 / R7 / R10: full sweep over both timebases
        for (int tb = 0; tb < 2; tb++) begin
            int per;
            per = (tb == 0) ? FAST : SLOW;
            write_ctrl(1, tb[0], 0);
            for (int n = 0; n < 32; n++) begin
                load_count(n[4:0]);
                wait_cycles((n + 1) * per - 1);
                check("R4 no status before expiry", timeout_status, 0);
                check("R8 no pulse before expiry", sys_reset, 0);
                @(negedge clk);
                check("R4 status at expiry", timeout_status, 1);
                check("R8 pulse starts at expiry", sys_reset, 1);
                check("R9 recovery code", fs_out, REC);
                wait_cycles(RSTC - 1);
                check("R8 pulse last cycle", sys_reset, 1);
                @(negedge clk);
                check("R8 pulse ended", sys_reset, 0);
                wait_cycles(3);
                check("R7 status sticky", timeout_status, 1);
                clear_status();
                check("R7 status cleared", timeout_status, 0);
                check("R9 fs restored", fs_out, STRAP);
                if (n < 2) begin
                    wait_cycles(3 * per + 2);
                    check("R10 stays disarmed", timeout_status, 0);
                    check("R10 no pulse", sys_reset, 0);
                end
            end
        end

        // R9: recovery overrides the software code
        write_ctrl(1, 0, 1);
        check("R3 sw code while enabled", fs_out, 5'h15);
        load_count(5'd1);
        wait_cycles(2 * FAST);
        check("R9 recovery with override", fs_out, REC);
        clear_status();
        check("R9 sw code restored", fs_out, 5'h15);
        write_ctrl(1, 0, 0);

        // R5: kick in the middle of a countdown
        load_count(5'd10);
        wait_cycles(21);
        load_count(5'd3);
        check("R5 reload value", count_now, 3);
        wait_cycles(4 * FAST - 1);
        check("R5 no early expiry", timeout_status, 0);
        @(negedge clk);
        check("R5 expiry from reload", timeout_status, 1);
        clear_status();

        // R7: time-out and clear on the same edge, time-out wins
        load_count(5'd0);
        wait_cycles(FAST - 1);
        status_clr = 1;
        @(negedge clk);
        status_clr = 0;
        check("R7 set wins over clear", timeout_status, 1);
        clear_status();
        check("R7 cleared afterwards", timeout_status, 0);

        // R6: disabling mid-count freezes the count
        load_count(5'd6);
        wait_cycles(2 * FAST);
        write_ctrl(0, 0, 0);
        wait_cycles(2);
        begin
            int held;
            held = count_now;
            wait_cycles(60);
            check("R6 count frozen", count_now, held);
            check("R6 no expiry after disable", timeout_status, 0);
        end

        finish_run();
    end

endmodule